// File: doc/BRIEF.md
# Guard-Bit Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit fixed-point signal processor. It holds eight 40-bit registers. Each of them can be loaded with a product, can have a product added to it, or can have a product subtracted from it. A command carries two 16-bit operands, a signedness bit for each operand, a fractional-format bit, an opcode and a destination select. The unit forms the exact product and widens it into the 40-bit accumulator format. It doubles the product when fractional format is requested, then writes the result into the chosen register on the same clock edge.

The eight bits above the 32-bit product are guard bits. They let long sums run without losing the sign. A sum that still leaves the 40-bit range wraps, and a sticky flag records it. A read-back port returns any register combinationally, so a result can be read in the cycle after its command.

Top module: `gmac_unit`

## Requirements
- R1: After reset all eight registers read zero and the overflow flag is low.
- R2: With both sign bits set, the operands are taken as two's complement and the register receives the exact signed product, sign-extended to 40 bits.
- R3: With exactly one sign bit set, that operand is two's complement and the other is unsigned, and the product is sign-extended to 40 bits.
- R4: With both sign bits clear, both operands are unsigned and the product is zero-extended, so bits 39:32 read zero.
- R5: With the fractional bit set, the widened product is shifted left by one before use. In signed mode, 0x8000 times 0x8000 gives 0x0080000000 (+1.0) with no clamping.
- R6: Opcode 00 (load) writes the aligned product into the destination and ignores its old value. Other registers do not change.
- R7: Opcode 01 (accumulate) writes destination plus aligned product, modulo 2^40.
- R8: Opcode 10 (deduct) writes destination minus aligned product, modulo 2^40.
- R9: A command accepted on a rising edge is visible on the read-back port right after that edge, with no added latency.
- R10: When an accumulate or deduct leaves the signed 40-bit range, the result wraps without saturating and the overflow flag goes high. The flag then stays high until reset. A load never sets it.
- R11: With the command valid input low, or with opcode 11, no register and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command is executed on this edge |
| cmdOp | input | 2 | 00 load, 01 accumulate, 10 deduct, 11 no operation |
| cmdDst | input | 3 | Destination register index |
| cmdSignA | input | 1 | Operand A is two's complement |
| cmdSignB | input | 1 | Operand B is two's complement |
| cmdFrac | input | 1 | Fractional format: shift product left by one |
| opA | input | 16 | First multiplier operand |
| opB | input | 16 | Second multiplier operand |
| rdSel | input | 3 | Read-back register index |
| rdData | output | 40 | Contents of the register chosen by rdSel |
| ovfFlag | output | 1 | Sticky overflow of the 40-bit accumulation |

## Verification
The bench sweeps every operand pairing from a boundary set (zero, one, both extremes, all ones and mid values) across all four signedness pairings, with and without the fractional shift. A design that mis-extends a mixed-sign or unsigned product shows wrong guard bits. A design that shifts before widening turns signed 0x8000 squared into a negative number. A long chain of fractional unsigned accumulations drives one register past the 40-bit range. This checks that the value wraps instead of clamping and that the flag rises at exactly that step and stays high. Idle and opcode-11 commands are checked against every register, so a write on an ignored command is caught.

// File: rtl/gmac_pkg.sv
package gmac_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_ACCUM  = 2'b01,
    OP_DEDUCT = 2'b10,
    OP_NONE   = 2'b11
  } gmacOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // write destination this edge
    logic useAcc;  // add to current destination value
    logic negate;  // subtract product instead of adding
  } gmacCtl_t;

endpackage

// File: rtl/gmac_ctrl.sv
module gmac_ctrl
  import gmac_pkg::*;
(
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output gmacCtl_t   ctl
);

  always_comb begin
    ctl = '0;
    if (cmdValid) begin
      unique case (gmacOp_e'(cmdOp))
        OP_LOAD:   ctl.wrEn = 1'b1;
        OP_ACCUM:  begin ctl.wrEn = 1'b1; ctl.useAcc = 1'b1; end
        OP_DEDUCT: begin ctl.wrEn = 1'b1; ctl.useAcc = 1'b1; ctl.negate = 1'b1; end
        default:   ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/gmac_dpath.sv
module gmac_dpath
  import gmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int GUARD = 8,
  parameter int NREGS = 8,
  localparam int PROD_W = 2 * OP_W,
  localparam int ACC_W  = PROD_W + GUARD,
  localparam int SEL_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gmacCtl_t          ctl,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic              signA,
  input  logic              signB,
  input  logic              frac,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ACC_W-1:0]  rdData,
  output logic              ovfFlag
);

  // operands widened by one bit so a single signed multiplier covers all modes
  logic signed [OP_W:0]       aWide, bWide;
  logic signed [2*OP_W+1:0]   fullProd;
  logic [PROD_W-1:0]          prod;
  logic [ACC_W-1:0]           prodExt, aligned, addend, base, sum;
  logic                       wrapped;
  logic [NREGS-1:0][ACC_W-1:0] regView;

  assign aWide    = {signA & opA[OP_W-1], opA};
  assign bWide    = {signB & opB[OP_W-1], opB};
  assign fullProd = aWide * bWide;
  assign prod     = fullProd[PROD_W-1:0];

  // guard bits: sign copies if any operand is signed, zeros otherwise
  assign prodExt = (signA | signB) ? {{GUARD{prod[PROD_W-1]}}, prod}
                                   : {{GUARD{1'b0}}, prod};

  // fractional shift after widening keeps 0x8000*0x8000 at +1.0
  assign aligned = frac ? {prodExt[ACC_W-2:0], 1'b0} : prodExt;
  assign addend  = ctl.negate ? (~aligned + 1'b1) : aligned;
  assign base    = ctl.useAcc ? regView[dstSel] : '0;
  assign sum     = base + addend;

  assign wrapped = ctl.wrEn & ctl.useAcc &
                   (base[ACC_W-1] == addend[ACC_W-1]) &
                   (sum[ACC_W-1]  != base[ACC_W-1]);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [ACC_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                q <= '0;
      else if (ctl.wrEn && dstSel == SEL_W'(i)) q <= sum;
    end
    assign regView[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ovfFlag <= 1'b0;
    else if (wrapped) ovfFlag <= 1'b1;
  end

  assign rdData = regView[rdSel];

endmodule

// File: rtl/gmac_unit.sv
module gmac_unit
  import gmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int GUARD = 8,
  parameter int NREGS = 8,
  localparam int ACC_W = 2 * OP_W + GUARD,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [SEL_W-1:0]  cmdDst,
  input  logic              cmdSignA,
  input  logic              cmdSignB,
  input  logic              cmdFrac,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [ACC_W-1:0]  rdData,
  output logic              ovfFlag
);

  gmacCtl_t ctl;

  gmac_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .ctl      (ctl)
  );

  gmac_dpath #(.OP_W(OP_W), .GUARD(GUARD), .NREGS(NREGS)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dstSel  (cmdDst),
    .signA   (cmdSignA),
    .signB   (cmdSignB),
    .frac    (cmdFrac),
    .opA     (opA),
    .opB     (opB),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/gmac_chk.sv
module gmac_chk #(
  parameter int OP_W  = 16,
  parameter int GUARD = 8,
  parameter int NREGS = 8,
  localparam int ACC_W = 2 * OP_W + GUARD,
  localparam int SEL_W = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic [SEL_W-1:0]  cmdDst,
  input logic              cmdSignA,
  input logic              cmdSignB,
  input logic              cmdFrac,
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic [SEL_W-1:0]  rdSel,
  input logic [ACC_W-1:0]  rdData,
  input logic              ovfFlag
);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(cmdValid) && ($past(cmdOp) == 2'b01 || $past(cmdOp) == 2'b10));

  // R6
  load_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b00 && !ovfFlag) |=> !ovfFlag);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid ##1 rdSel == $past(rdSel)) |-> rdData == $past(rdData));

  // R4
  unsigned_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b00 && !cmdSignA && !cmdSignB && !cmdFrac
     ##1 rdSel == $past(cmdDst))
    |-> rdData == (ACC_W'($past(opA)) * ACC_W'($past(opB))));

endmodule

bind gmac_unit gmac_chk #(.OP_W(OP_W), .GUARD(GUARD), .NREGS(NREGS)) u_chk (.*);

// File: tb/gmac_unit_bench.sv
module gmac_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'b00;
  logic [2:0]  cmdDst = '0;
  logic        cmdSignA = 1'b0, cmdSignB = 1'b0, cmdFrac = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [2:0]  rdSel = '0;
  logic [39:0] rdData;
  logic        ovfFlag;

  int  nTests = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  logic [39:0] model [8];
  bit          modelOvf = 1'b0;

  always #5 clk = ~clk;

  gmac_unit u_gmac_unit (.*);

  function automatic longint sx40(logic [39:0] v);
    longint r = longint'(v);
    if (v[39]) r = r - (longint'(1) << 40);
    return r;
  endfunction

  function automatic longint expProd(logic [15:0] a, logic [15:0] b,
                                     bit sa, bit sb, bit fr);
    longint av = sa ? longint'($signed(a)) : longint'(a);
    longint bv = sb ? longint'($signed(b)) : longint'(b);
    longint p  = av * bv;
    if (fr) p = p * 2;
    return p;
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkFlag(string tag, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: ovfFlag actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int r = 0; r < 8; r++) begin
      rdSel = 3'(r);
      #1;
      check(tag, rdData, model[r]);
    end
    checkFlag(tag, ovfFlag, modelOvf);
  endtask

  // issue one command at a negedge, sample one cycle later at the next negedge
  task automatic doOp(string tag, logic vld, logic [1:0] op, logic [2:0] d,
                      logic [15:0] a, logic [15:0] b, bit sa, bit sb, bit fr);
    longint p, s;
    cmdValid = vld; cmdOp = op; cmdDst = d; opA = a; opB = b;
    cmdSignA = sa; cmdSignB = sb; cmdFrac = fr; rdSel = d;
    p = expProd(a, b, sa, sb, fr);
    if (vld && op != 2'b11) begin
      if (op == 2'b00) s = p;
      else begin
        s = (op == 2'b01) ? sx40(model[d]) + p : sx40(model[d]) - p;
        if (s > ((longint'(1) << 39) - 1) || s < -(longint'(1) << 39)) modelOvf = 1'b1;
      end
      model[d] = s[39:0];
    end
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check(tag, rdData, model[d]);
    checkFlag(tag, ovfFlag, modelOvf);
  endtask

  logic [15:0] vals [8];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h0002; vals[6] = 16'h1234; vals[7] = 16'hC001;
    for (int r = 0; r < 8; r++) model[r] = '0;

    repeat (3) @(negedge clk);
    // R1: reset state
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // sweep loads over all signedness pairings and both formats
    for (int m = 0; m < 4; m++)
      for (int fr = 0; fr < 2; fr++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            string tag;
            if (fr == 1)      tag = "R5";
            else if (m == 3)  tag = "R2";
            else if (m == 0)  tag = "R4";
            else              tag = "R3";
            doOp(tag, 1'b1, 2'b00, 3'((i + j) % 8), vals[i], vals[j],
                 m[0], m[1], fr[0]);
          end

    // R5: signed fractional extreme reaches +1.0
    doOp("R5", 1'b1, 2'b00, 3'd1, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1);
    check("R5", rdData, 40'h00_8000_0000);

    // R6: load overwrites old value, neighbours untouched
    doOp("R6", 1'b1, 2'b01, 3'd3, 16'h4000, 16'h4000, 1'b1, 1'b1, 1'b0);
    doOp("R6", 1'b1, 2'b00, 3'd3, 16'h0002, 16'h0003, 1'b1, 1'b1, 1'b0);
    check("R6", rdData, 40'd6);
    checkAll("R6");

    // R7: accumulation
    doOp("R7", 1'b1, 2'b01, 3'd3, 16'hFFFD, 16'h0007, 1'b1, 1'b1, 1'b0);
    check("R7", rdData, 40'hFF_FFFF_FFF1);
    doOp("R7", 1'b1, 2'b01, 3'd3, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    doOp("R7", 1'b1, 2'b01, 3'd3, 16'h8000, 16'hFFFF, 1'b1, 1'b0, 1'b0);

    // R8: deduction, including going negative from zero
    doOp("R8", 1'b1, 2'b00, 3'd4, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b0);
    doOp("R8", 1'b1, 2'b10, 3'd4, 16'h0005, 16'h0006, 1'b1, 1'b1, 1'b0);
    check("R8", rdData, 40'hFF_FFFF_FFE2);
    doOp("R8", 1'b1, 2'b10, 3'd3, 16'h7FFF, 16'h8000, 1'b0, 1'b1, 1'b1);

    // R9: result readable right after the accepting edge
    doOp("R9", 1'b1, 2'b00, 3'd2, 16'h0003, 16'h0004, 1'b0, 1'b0, 1'b0);
    check("R9", rdData, 40'd12);

    // R11: idle cycle and opcode 11 change nothing
    doOp("R11", 1'b0, 2'b00, 3'd2, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b0);
    checkAll("R11");
    doOp("R11", 1'b1, 2'b11, 3'd5, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    checkAll("R11");

    // R10: long unsigned fractional chain wraps past 2^39
    doOp("R10", 1'b1, 2'b00, 3'd6, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 70; k++)
      doOp("R10", 1'b1, 2'b01, 3'd6, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    checkFlag("R10", ovfFlag, 1'b1);
    doOp("R10", 1'b1, 2'b00, 3'd6, 16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0);
    doOp("R10", 1'b0, 2'b00, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
    checkFlag("R10", ovfFlag, 1'b1);
    checkAll("R10");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule